// File: doc/BRIEF.md
# Region-Configurable External Bus Decoder

This block sits between a processor's load/store port and an external memory and I/O bus. The 4 GB memory space is cut into four equal regions, picked by the two most significant address bits. Each region carries its own port width and its own wait-state count, both taken from configuration inputs. One region is set aside for dynamic memory. Requests that fall in it are handed whole to an external DRAM controller port and never touch the static bus. The other three regions drive chip selects and read/write strobes for SRAM, EPROM and similar parts directly.

A separate I/O space, chosen by a select input on the request, reaches sixteen devices. Each device has its own wait-state count, indexed by address bits [9:6]. When a 16- or 32-bit access targets a narrower port, the block breaks it into consecutive beats, lowest address first. Write data is steered onto the low lanes for each beat, and read data is gathered back into one word. The requester sees a single-cycle ready pulse with the assembled read data once the whole access is finished.

Top module: `region_bus_decoder`

## Requirements
- R1: A memory request outside the DRAM region asserts only `memCs[region]`, where region is `reqAddr[31:30]`, and holds it for every strobe cycle of the access; `ioCs` stays low.
- R2: A memory request in region `DRAM_REGION` (default 0) drives no chip select and no strobe. It holds `dramReq` high, with `dramAddr`, `dramWrite`, `dramSize` and `dramWdata` equal to the request, until `dramAck`. `respReady` rises in the cycle after the acknowledge, and a read returns `dramRdata`.
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. The two-bit width code of region r is `regionWidth[2r+1:2r]`: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. An access takes max(1, access bytes / port bytes) beats, and beat k puts address `reqAddr + k*portBytes` on `busAddr`.
- R4: Each beat holds its strobe for 1 + w cycles. For region r, w is `regionWait[4r+3:4r]`.
- R5: During beat k of a write, the low min(portBytes, accessBytes) bytes of `busWdata` equal those bytes of `reqWdata` shifted right by 8*k*portBytes bits.
- R6: Byte i of read data (i below access bytes) is taken from `busRdata` lane i mod portBytes during beat i / portBytes. Bytes at or above the access size read as zero, and lanes above the port width are ignored.
- R7: An I/O request (`reqIo` = 1) asserts only `ioCs` and makes one 32-bit beat whatever the address region, DRAM region included. The beat is held for 1 + `ioWait[4d+3:4d]` cycles, where d = `reqAddr[9:6]`.
- R8: `respReady` is high for exactly one cycle, the cycle after the last strobe cycle. After reset every strobe, select, `dramReq` and `respReady` is low.
- R9: A `reqValid` seen while an access is in progress is ignored. The running access keeps its addresses, and no further access follows it.
- R10: `busRd` is high during strobe cycles of reads, `busWr` during strobe cycles of writes, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request pulse, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqSize | input | 2 | 0 byte, 1 half, 2/3 word |
| reqAddr | input | 32 | Request byte address |
| reqWdata | input | 32 | Write data, right-justified |
| respReady | output | 1 | One-cycle completion pulse |
| respRdata | output | 32 | Assembled read data, valid with respReady |
| regionWidth | input | 8 | Two-bit width code per region |
| regionWait | input | 16 | Four-bit wait count per region |
| ioWait | input | 64 | Four-bit wait count per I/O device |
| memCs | output | 4 | Per-region chip select (DRAM bit always 0) |
| ioCs | output | 1 | I/O space select |
| busAddr | output | 32 | Beat address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | 32 | Beat write data on low lanes |
| busRdata | input | 32 | Beat read data on low lanes |
| dramReq | output | 1 | Request to DRAM controller, held until acknowledge |
| dramWrite | output | 1 | DRAM request direction |
| dramSize | output | 2 | DRAM request size code |
| dramAddr | output | 32 | DRAM request address |
| dramWdata | output | 32 | DRAM write data |
| dramAck | input | 1 | DRAM controller completion |
| dramRdata | input | 32 | DRAM read data, valid with dramAck |

## Verification
The assertions assume that `dramAck` is only raised while `dramReq` is high. They also assume that addresses are aligned to the access size and that the width and wait configuration does not change while an access is running. The stimulus rewrites the configuration only between accesses, when the block is idle, and builds every address from a word-aligned base. Its DRAM model pulses the acknowledge only after it has seen the request. The one deliberate misuse is a request pulse in the middle of an access. That case exists to show the pulse is dropped.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int DATA_W     = 32;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int SIZE_W     = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_DRAM   = 2'd2,
    ST_DONE   = 2'd3
  } rbdState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic busActive;
    logic dramActive;
    logic capture;
    logic nextBeat;
    logic dramCapture;
  } rbdStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic lastBeat;
    logic newIsDram;
  } rbdStatus_t;
endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              dramAck,
  input  rbdStatus_t        status,
  input  logic [WAIT_W-1:0] waitVal,
  output rbdStrobes_t       strb,
  output logic              respReady
);
  rbdState_t         state, stateNext;
  logic [WAIT_W-1:0] waitCnt;

  always_comb begin
    strb             = '0;
    strb.load        = (state == ST_IDLE) && reqValid;
    strb.busActive   = (state == ST_STROBE);
    strb.dramActive  = (state == ST_DRAM);
    strb.capture     = (state == ST_STROBE) && (waitCnt == waitVal);
    strb.nextBeat    = strb.capture && !status.lastBeat;
    strb.dramCapture = (state == ST_DRAM) && dramAck;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = status.newIsDram ? ST_DRAM : ST_STROBE;
      ST_STROBE: if (strb.capture && status.lastBeat) stateNext = ST_DONE;
      ST_DRAM:   if (dramAck) stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_STROBE || strb.capture) waitCnt <= '0;
      else                                    waitCnt <= waitCnt + 1'b1;
    end
  end

  assign respReady = (state == ST_DONE);
endmodule

// File: rtl/rbd_dpath.sv
module rbd_dpath
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 2,
  parameter int WAIT_W      = 4,
  parameter int IO_SEL_LSB  = 6,
  parameter int IO_SEL_BITS = 4,
  parameter int DRAM_REGION = 0
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  rbdStrobes_t                           strb,
  input  logic                                  reqWrite,
  input  logic                                  reqIo,
  input  logic [SIZE_W-1:0]                     reqSize,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [DATA_W-1:0]                     reqWdata,
  input  logic [(2<<REGION_BITS)-1:0]           regionWidth,
  input  logic [(WAIT_W<<REGION_BITS)-1:0]      regionWait,
  input  logic [(WAIT_W<<IO_SEL_BITS)-1:0]      ioWait,
  input  logic [DATA_W-1:0]                     busRdata,
  input  logic [DATA_W-1:0]                     dramRdata,
  output rbdStatus_t                            status,
  output logic [WAIT_W-1:0]                     waitVal,
  output logic [(1<<REGION_BITS)-1:0]           memCs,
  output logic                                  ioCs,
  output logic [ADDR_W-1:0]                     busAddr,
  output logic                                  busRd,
  output logic                                  busWr,
  output logic [DATA_W-1:0]                     busWdata,
  output logic                                  dramWrite,
  output logic [SIZE_W-1:0]                     dramSize,
  output logic [ADDR_W-1:0]                     dramAddr,
  output logic [DATA_W-1:0]                     dramWdata,
  output logic [DATA_W-1:0]                     respRdata
);
  localparam int NUM_REGIONS = 1 << REGION_BITS;

  logic [ADDR_W-1:0]      addrQ;
  logic [DATA_W-1:0]      wdataQ, rdataQ;
  logic                   writeQ, ioQ;
  logic [SIZE_W-1:0]      sizeQ;
  logic [1:0]             beatIdx;

  logic [REGION_BITS-1:0] region;
  logic [IO_SEL_BITS-1:0] ioDev;
  logic [1:0]             widthCode, pbLog, sizeLog, beatsLog;
  logic [2:0]             portBytes, accessBytes, beatOffset;
  logic [1:0]             lastIdx;

  assign region   = addrQ[ADDR_W-1 -: REGION_BITS];
  assign ioDev    = addrQ[IO_SEL_LSB +: IO_SEL_BITS];
  assign widthCode = regionWidth[region*2 +: 2];
  assign waitVal  = ioQ ? ioWait[ioDev*WAIT_W +: WAIT_W]
                        : regionWait[region*WAIT_W +: WAIT_W];

  always_comb begin
    if (ioQ || widthCode[1]) pbLog = 2'd2;
    else                     pbLog = widthCode;
    sizeLog     = (sizeQ[1]) ? 2'd2 : sizeQ;
    beatsLog    = (sizeLog > pbLog) ? (sizeLog - pbLog) : 2'd0;
    portBytes   = 3'd1 << pbLog;
    accessBytes = 3'd1 << sizeLog;
    lastIdx     = 2'((3'd1 << beatsLog) - 3'd1);
    beatOffset  = 3'({1'b0, beatIdx} << pbLog);
  end

  assign status.lastBeat  = (beatIdx == lastIdx);
  assign status.newIsDram = !reqIo &&
    (reqAddr[ADDR_W-1 -: REGION_BITS] == REGION_BITS'(DRAM_REGION));

  // request holding registers and beat sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      writeQ  <= 1'b0;
      ioQ     <= 1'b0;
      sizeQ   <= '0;
      beatIdx <= '0;
    end else if (strb.load) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      writeQ  <= reqWrite;
      ioQ     <= reqIo;
      sizeQ   <= reqSize;
      beatIdx <= '0;
    end else if (strb.nextBeat) begin
      beatIdx <= beatIdx + 2'd1;
    end
  end

  // read assembly: byte i comes from beat i/portBytes, lane i%portBytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.load) begin
      rdataQ <= '0;
    end else if (strb.capture && !writeQ) begin
      for (int i = 0; i < DATA_BYTES; i++) begin
        if ((i >> pbLog) == int'(beatIdx) && i < int'(accessBytes))
          rdataQ[8*i +: 8] <= busRdata[8*(i & (int'(portBytes) - 1)) +: 8];
      end
    end else if (strb.dramCapture) begin
      rdataQ <= dramRdata;
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gCs
    if (r == DRAM_REGION) begin : gDram
      assign memCs[r] = 1'b0;
    end else begin : gStatic
      assign memCs[r] = strb.busActive && !ioQ && (region == REGION_BITS'(r));
    end
  end

  assign ioCs      = strb.busActive && ioQ;
  assign busRd     = strb.busActive && !writeQ;
  assign busWr     = strb.busActive && writeQ;
  assign busAddr   = addrQ + ADDR_W'(beatOffset);
  assign busWdata  = wdataQ >> {beatOffset, 3'b000};
  assign dramWrite = writeQ;
  assign dramSize  = sizeQ;
  assign dramAddr  = addrQ;
  assign dramWdata = wdataQ;
  assign respRdata = rdataQ;
endmodule

// File: rtl/region_bus_decoder.sv
module region_bus_decoder
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 2,
  parameter int WAIT_W      = 4,
  parameter int IO_SEL_LSB  = 6,
  parameter int IO_SEL_BITS = 4,
  parameter int DRAM_REGION = 0
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic                              reqIo,
  input  logic [1:0]                        reqSize,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [31:0]                       reqWdata,
  output logic                              respReady,
  output logic [31:0]                       respRdata,
  input  logic [(2<<REGION_BITS)-1:0]       regionWidth,
  input  logic [(WAIT_W<<REGION_BITS)-1:0]  regionWait,
  input  logic [(WAIT_W<<IO_SEL_BITS)-1:0]  ioWait,
  output logic [(1<<REGION_BITS)-1:0]       memCs,
  output logic                              ioCs,
  output logic [ADDR_W-1:0]                 busAddr,
  output logic                              busRd,
  output logic                              busWr,
  output logic [31:0]                       busWdata,
  input  logic [31:0]                       busRdata,
  output logic                              dramReq,
  output logic                              dramWrite,
  output logic [1:0]                        dramSize,
  output logic [ADDR_W-1:0]                 dramAddr,
  output logic [31:0]                       dramWdata,
  input  logic                              dramAck,
  input  logic [31:0]                       dramRdata
);
  rbdStrobes_t       strb;
  rbdStatus_t        status;
  logic [WAIT_W-1:0] waitVal;

  rbd_ctrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dramAck(dramAck),
    .status(status), .waitVal(waitVal), .strb(strb), .respReady(respReady)
  );

  rbd_dpath #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .WAIT_W(WAIT_W),
    .IO_SEL_LSB(IO_SEL_LSB), .IO_SEL_BITS(IO_SEL_BITS), .DRAM_REGION(DRAM_REGION)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqIo(reqIo), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .regionWidth(regionWidth), .regionWait(regionWait), .ioWait(ioWait),
    .busRdata(busRdata), .dramRdata(dramRdata),
    .status(status), .waitVal(waitVal),
    .memCs(memCs), .ioCs(ioCs), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .dramWrite(dramWrite), .dramSize(dramSize),
    .dramAddr(dramAddr), .dramWdata(dramWdata), .respRdata(respRdata)
  );

  assign dramReq = strb.dramActive;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int REGION_BITS = 2,
  parameter int DRAM_REGION = 0
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [(1<<REGION_BITS)-1:0] memCs,
  input logic                        ioCs,
  input logic                        busRd,
  input logic                        busWr,
  input logic                        respReady,
  input logic                        dramReq,
  input logic                        dramAck
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memCs, ioCs})); // R1

  AST_STROBE_HAS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (|memCs || ioCs)); // R1

  AST_NO_DRAM_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !memCs[DRAM_REGION]); // R2

  AST_DRAM_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    dramReq |-> !(busRd || busWr || ioCs || |memCs)); // R2

  AST_DRAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dramReq && !dramAck) |=> dramReq); // R2

  AST_DRAM_ACK_READY: assert property (@(posedge clk) disable iff (!rstN)
    (dramReq && dramAck) |=> respReady); // R2

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respReady |=> !respReady); // R8

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> !(busRd || busWr || dramReq)); // R8

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R10
endmodule

bind region_bus_decoder rbd_checker #(
  .REGION_BITS(REGION_BITS), .DRAM_REGION(DRAM_REGION)
) uChk (
  .clk(clk), .rstN(rstN), .memCs(memCs), .ioCs(ioCs), .busRd(busRd),
  .busWr(busWr), .respReady(respReady), .dramReq(dramReq), .dramAck(dramAck)
);

// File: tb/sim_region_bus_decoder.sv
module sim_region_bus_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic        respReady;
  logic [31:0] respRdata;
  logic [7:0]  regionWidth = '0;
  logic [15:0] regionWait = '0;
  logic [63:0] ioWait = '0;
  logic [3:0]  memCs;
  logic        ioCs, busRd, busWr, dramReq, dramWrite;
  logic [31:0] busAddr, busWdata, busRdata, dramAddr, dramWdata;
  logic [1:0]  dramSize;
  logic        dramAck = 1'b0;
  logic [31:0] dramRdata = '0;

  int checks = 0;
  int fails = 0;
  int curPb = 4;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  region_bus_decoder u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respReady(respReady), .respRdata(respRdata),
    .regionWidth(regionWidth), .regionWait(regionWait), .ioWait(ioWait),
    .memCs(memCs), .ioCs(ioCs), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata),
    .dramReq(dramReq), .dramWrite(dramWrite), .dramSize(dramSize),
    .dramAddr(dramAddr), .dramWdata(dramWdata), .dramAck(dramAck), .dramRdata(dramRdata)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ 8'h5C ^ {a[31:30], a[11:6]};
  endfunction

  // static bus slave: valid bytes on the lanes of the port, junk above
  always_comb begin
    for (int l = 0; l < 4; l++)
      busRdata[8*l +: 8] = (l < curPb) ? memByte(busAddr + 32'(l)) : 8'hEE;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runAccess(input logic wr, input logic io, input logic [1:0] size,
                           input logic [31:0] addr, input logic [31:0] wdata,
                           input int dramDelay, input bit poke);
    int region, wc, pb, ab, beats, w, n, cyc, strobes, dramSeen, beat, nb;
    bit isDram;
    logic [31:0] mask, expR;
    region = int'(addr[31:30]);
    isDram = !io && region == 0;
    wc = int'(regionWidth[region*2 +: 2]);
    pb = io ? 4 : (wc >= 2 ? 4 : (1 << wc));
    ab = (size >= 2) ? 4 : (1 << size);
    beats = (ab > pb) ? ab / pb : 1;
    w = io ? int'(ioWait[int'(addr[9:6])*4 +: 4]) : int'(regionWait[region*4 +: 4]);
    n = beats * (w + 1);
    nb = (pb < ab) ? pb : ab;
    mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 1);
    curPb = pb;
    dramRdata = 32'hD00D_0000 ^ addr;

    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqIo = io; reqSize = size;
    reqAddr = addr; reqWdata = wdata;
    @(negedge clk);
    reqValid = 0;
    cyc = 1; strobes = 0; dramSeen = 0;
    while (!respReady && cyc < 300) begin
      dramAck = 0;
      reqValid = 0;
      if (isDram) begin
        check(!(busRd || busWr) && memCs == 0 && !ioCs, "R2 bus quiet", {memCs, ioCs}, 0);
        if (dramReq) begin
          if (dramSeen == 0) begin
            check(dramAddr == addr, "R2 dramAddr", dramAddr, addr);
            check(dramWrite == wr && dramSize == size, "R2 dram ctl", {dramWrite, dramSize}, {wr, size});
            if (wr) check(dramWdata == wdata, "R2 dramWdata", dramWdata, wdata);
          end
          if (dramSeen == dramDelay) dramAck = 1;
          dramSeen++;
        end
      end
      if (busRd || busWr) begin
        beat = strobes / (w + 1);
        check(busAddr == addr + 32'(beat*pb), "R3 beat address", busAddr, addr + 32'(beat*pb));
        check(busWr == wr && busRd == !wr, "R10 strobe kind", {busRd, busWr}, {!wr, wr});
        if (io) check(ioCs && memCs == 0, "R7 io select", {memCs, ioCs}, 1);
        else    check(!ioCs && memCs == (4'd1 << region), "R1 region select", {memCs, ioCs}, (1 << region) << 1);
        if (wr) check((busWdata & mask) == ((wdata >> (8*pb*beat)) & mask), "R5 write lanes",
                      busWdata & mask, (wdata >> (8*pb*beat)) & mask);
        strobes++;
      end
      if (poke && cyc == 2) begin
        reqValid = 1; reqAddr = addr ^ 32'h4000_0040; reqWrite = !wr;
      end
      @(negedge clk);
      cyc++;
    end
    dramAck = 0;
    reqValid = 0;
    if (isDram) begin
      check(cyc == dramDelay + 2, "R2 ready latency", cyc, dramDelay + 2);
      if (!wr) check(respRdata == dramRdata, "R2 dram read data", respRdata, dramRdata);
    end else begin
      check(cyc == n + 1, io ? "R7 io latency" : "R4 ready latency", cyc, n + 1);
      check(strobes == n, "R4 strobe cycles", strobes, n);
      if (!wr) begin
        expR = 0;
        for (int i = 0; i < ab; i++) expR[8*i +: 8] = memByte(addr + 32'(i));
        check(respRdata == expR, "R6 read assembly", respRdata, expR);
      end
    end
    @(negedge clk);
    check(!respReady, "R8 single-cycle ready", respReady, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        check(!(busRd || busWr || ioCs || dramReq) && memCs == 0, "R9 late request dropped",
              {busRd, busWr, ioCs, dramReq, memCs}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!respReady && !busRd && !busWr && memCs == 0 && !ioCs && !dramReq,
          "R8 reset state", {respReady, busRd, busWr, memCs, ioCs, dramReq}, 0);
    rstN = 1;
    @(negedge clk);

    // R1 R3 R4 R5 R6: sweep static regions, widths, sizes, directions, waits
    for (int r = 1; r < 4; r++)
      for (int wc = 0; wc < 4; wc++)
        for (int wv = 0; wv < 2; wv++)
          for (int sz = 0; sz < 4; sz++)
            for (int wr = 0; wr < 2; wr++) begin
              regionWidth = 8'h00;
              regionWidth[r*2 +: 2] = 2'(wc);
              regionWait = 16'hFFFF;
              regionWait[r*4 +: 4] = (wv == 0) ? 4'd0 : 4'd3;
              runAccess(wr[0], 1'b0, 2'(sz), {2'(r), 30'h0000_1230} + 32'(sz*16),
                        32'hA1B2_C3D4 ^ 32'(r*wc*77 + sz), 0, 1'b0);
            end

    // R2: DRAM region with several acknowledge delays
    for (int d = 0; d < 4; d++)
      for (int wr = 0; wr < 2; wr++)
        runAccess(wr[0], 1'b0, 2'(d % 3), 32'h0000_0800 + 32'(d*4), 32'h1357_9BDF + 32'(d), d, 1'b0);

    // R7: every I/O device with its own wait, region bits varied (DRAM region too)
    for (int dv = 0; dv < 16; dv++) ioWait[dv*4 +: 4] = 4'(15 - dv);
    regionWidth = 8'h00;
    for (int dv = 0; dv < 16; dv++)
      runAccess(dv[0], 1'b1, 2'(dv % 4), {2'(dv % 4), 20'h0, 4'(dv), 6'h0},
                32'hCAFE_0000 + 32'(dv), 0, 1'b0);

    // R9: request pulsed mid-access on an 8-bit region with waits
    regionWidth = 8'h00;
    regionWait = 16'h0010;
    runAccess(1'b0, 1'b0, 2'd2, 32'h4000_2000, 32'h0, 0, 1'b1);
    runAccess(1'b1, 1'b0, 2'd2, 32'h4000_2004, 32'h8899_AABB, 0, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule